// File: doc/BRIEF.md
# Serial-Port Sequencer for a 16-bit Successive-Approximation Converter

This block is the digital control of a 16-bit successive-approximation converter as seen from its three-wire serial port. A host lowers an active-low select line and toggles a serial clock. The block counts the falling clock edges of each frame and walks through three phases: acquire, convert and shift-out. It latches the converter's 16-bit result at the edge where conversion starts. It then drives the data line with eight zero bits followed by the result, most significant bit first. Clock edges past the end of the frame give trailing zeros. Raising the select line at any point ends the frame, clears all frame state and returns the block to its low-power idle state. If this happens during a conversion, the conversion is abandoned.

The host's select and serial clock are treated as signals that are synchronous to the block's own clock. Each is sampled once per cycle, and a serial-clock fall is detected when the previous sample was high and the current one is low. Every output is registered, so it answers one cycle after the input change that causes it. The high-impedance data line is modelled as a data bit plus an output-enable. The analog converter is modelled as a register that captures `sample_in`.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset, `dout_oe` is 0, `dout` is 0, `shutdown` is 1 and `phase` is 0 (idle).
- R2: One cycle after `cs_n` is sampled low, `dout_oe` is 1, `dout` is 0, `shutdown` is 0 and `phase` is 1 (acquire).
- R3: While selected, each falling `sclk` edge advances the frame by one and rising edges change nothing. `phase` is 1 (acquire) after edges 1 to 5, 2 (convert) after edges 6 to 23, and 3 (done) after edge 24 and any later edge.
- R4: The value on `sample_in` at the 6th falling edge becomes the result of the frame. Later changes of `sample_in` within the frame do not alter the bits that are shifted out.
- R5: `dout` is 0 after falling edges 0 through 7 of a frame (eight leading zeros).
- R6: After falling edge k, for k from 8 to 23, `dout` is bit (23 - k) of the result. The most significant bit comes first.
- R7: After edge 24 and any further falling edges while still selected, `dout` is 0 and `phase` stays 3. The edge count never wraps into a new frame.
- R8: One cycle after `cs_n` is sampled high, `dout_oe` is 0, `dout` is 0, `shutdown` is 1 and `phase` is 0, whatever the frame's progress. This holds even if a falling `sclk` edge occurs in the same cycle.
- R9: After a deselect, whether the frame finished or was cut short, the next frame restarts from edge zero and captures a fresh result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial port |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample_in | input | 16 | Result presented by the converter model |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Data output enable; 0 means high impedance |
| shutdown | output | 1 | Low-power status, high while not selected |
| phase | output | 2 | 0 idle, 1 acquire, 2 convert, 3 done |

## Verification
The two functions that can meet in one cycle are frame advance and deselect. A falling serial-clock edge wants to step the count and shift the next bit, while a rising select wants to clear everything. The bench provokes this by driving `sclk` low and `cs_n` high at the same instant. It does so once in the middle of the data bits and once near the start of a frame. It judges the cycle by requiring the idle outputs with no shifted bit visible. It then requires the following frame to begin with eight fresh zeros and the new sample, which shows that no stale count or shift-register content survived.

// File: rtl/sar_ctrl_pkg.sv
// Package: shared phase encoding for the serial-port sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

endpackage

// File: rtl/sar_edge_sense.sv
// Module: samples the host select and serial clock, and produces the
// selected flag, the registered "active" state and a one-cycle step pulse
// per falling serial-clock edge seen during an established selection.
// Assumes: cs_n and sclk are synchronous to clk (no metastability filter).
module sar_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic sel,
    output logic active_q,
    output logic step
);

    logic sclk_q;

    // Remember last serial-clock sample and last selection state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            active_q <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            active_q <= ~cs_n;
        end
    end

    // A step is a falling serial-clock edge while selected in both samples.
    always_comb begin
        sel  = ~cs_n;
        step = sclk_q & ~sclk & sel & active_q;
    end

    // R8
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !active_q);

    // R2
    select_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> active_q);

endmodule

// File: rtl/sar_frame_seq.sv
// Module: counts falling serial-clock edges of a frame, saturating at the
// frame length, and decodes the phase plus capture and load strobes.
// Assumes: CONV_EDGE < LEAD_ZEROS, so the result is captured before it is
// loaded for shifting.
module sar_frame_seq
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int LEAD_ZEROS = 8,
    parameter int CONV_EDGE  = 6,
    localparam int FRAME     = LEAD_ZEROS + DATA_W,
    localparam int CNT_W     = $clog2(FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             active_q,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output phase_e           phase,
    output logic             cap_en,
    output logic             load_en
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] CAP_AT   = CNT_W'(CONV_EDGE - 1);
    localparam logic [CNT_W-1:0] LOAD_AT  = CNT_W'(LEAD_ZEROS - 1);
    localparam logic [CNT_W-1:0] CONV_AT  = CNT_W'(CONV_EDGE);

    // Edge counter: cleared while deselected, saturates at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!sel) begin
            cnt <= '0;
        end else if (step && cnt != CNT_FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobes for capturing and loading, and the externally visible phase.
    always_comb begin
        cap_en  = step && (cnt == CAP_AT);
        load_en = step && (cnt == LOAD_AT);
        if (!active_q)
            phase = PH_IDLE;
        else if (cnt < CONV_AT)
            phase = PH_ACQ;
        else if (cnt < CNT_FULL)
            phase = PH_CONV;
        else
            phase = PH_DONE;
    end

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt != CNT_FULL) |=> cnt == $past(cnt) + 1'b1);

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> cnt == '0);

endmodule

// File: rtl/sar_conv_stub.sv
// Module: abstract converter; holds the result captured at conversion start.
// Assumes: cap_en pulses at most once per frame; deselect clears the result.
module sar_conv_stub #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] result
);

    // Capture the sample at conversion start; abort clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (!sel) begin
            result <= '0;
        end else if (cap_en) begin
            result <= sample_in;
        end
    end

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !cap_en) |=> $stable(result));

endmodule

// File: rtl/sar_shift_out.sv
// Module: serialises the result MSB first; zeros before the load and after
// the last bit, cleared on deselect.
// Assumes: load_en and step come from the same falling edge.
module sar_shift_out #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              step,
    input  logic              load_en,
    input  logic [DATA_W-1:0] result,
    output logic              dout
);

    logic [DATA_W-1:0] sreg;

    // Load on the first data edge, then shift zeros in behind the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            dout <= 1'b0;
        end else if (!sel) begin
            sreg <= '0;
            dout <= 1'b0;
        end else if (load_en) begin
            dout <= result[DATA_W-1];
            sreg <= {result[DATA_W-2:0], 1'b0};
        end else if (step) begin
            dout <= sreg[DATA_W-1];
            sreg <= {sreg[DATA_W-2:0], 1'b0};
        end
    end

    // R3
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !step) |=> $stable(dout));

endmodule

// File: rtl/sar_serial_ctrl.sv
// Module: top of the serial-port sequencer. Joins edge sensing, frame
// sequencing, the converter model and the output shifter.
// Assumes: host signals synchronous to clk; sclk idles low between frames.
module sar_serial_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int LEAD_ZEROS = 8,
    parameter int CONV_EDGE  = 6,
    localparam int FRAME     = LEAD_ZEROS + DATA_W,
    localparam int CNT_W     = $clog2(FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              dout,
    output logic              dout_oe,
    output logic              shutdown,
    output logic [1:0]        phase
);

    logic              sel;
    logic              active_q;
    logic              step;
    logic [CNT_W-1:0]  cnt;
    phase_e            phase_w;
    logic              cap_en;
    logic              load_en;
    logic [DATA_W-1:0] result;

    sar_edge_sense u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sel      (sel),
        .active_q (active_q),
        .step     (step)
    );

    sar_frame_seq #(
        .DATA_W     (DATA_W),
        .LEAD_ZEROS (LEAD_ZEROS),
        .CONV_EDGE  (CONV_EDGE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .active_q (active_q),
        .step     (step),
        .cnt      (cnt),
        .phase    (phase_w),
        .cap_en   (cap_en),
        .load_en  (load_en)
    );

    sar_conv_stub #(.DATA_W(DATA_W)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .cap_en    (cap_en),
        .sample_in (sample_in),
        .result    (result)
    );

    sar_shift_out #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .step    (step),
        .load_en (load_en),
        .result  (result),
        .dout    (dout)
    );

    // Drive the port-level status from the registered selection state.
    always_comb begin
        dout_oe  = active_q;
        shutdown = ~active_q;
        phase    = phase_w;
    end

    // R8
    tristate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    // R5
    data_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout |-> phase == PH_CONV);

    // R1
    status_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown != dout_oe);

endmodule

// File: tb/sar_serial_ctrl_tb.sv
module sar_serial_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [15:0] sample_in = '0;
    logic        dout;
    logic        dout_oe;
    logic        shutdown;
    logic [1:0]  phase;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic       d;
        logic       oe;
        logic       sd;
        logic [1:0] ph;
        int         due;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sar_serial_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sample_in (sample_in),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .shutdown  (shutdown),
        .phase     (phase)
    );

    // Driver helper: queue the outputs expected one cycle from now.
    task automatic push(input logic d, input logic oe, input logic sd,
                        input logic [1:0] ph, input string req);
        exp_t e;
        e.d = d; e.oe = oe; e.sd = sd; e.ph = ph; e.due = cyc + 1; e.req = req;
        exp_q.push_back(e);
        last_exp = e;
    endtask

    // Monitor: compare every due item against the ports away from the edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (dout !== e.d || dout_oe !== e.oe || shutdown !== e.sd || phase !== e.ph) begin
                errors++;
                $display("FAIL %s: got dout=%b oe=%b sd=%b ph=%0d, expected dout=%b oe=%b sd=%b ph=%0d",
                         e.req, dout, dout_oe, shutdown, phase, e.d, e.oe, e.sd, e.ph);
            end
        end
    end

    function automatic logic exp_bit(input logic [15:0] data, input int k);
        if (k >= 8 && k <= 23) return data[23 - k];
        return 1'b0;
    endfunction

    function automatic logic [1:0] exp_ph(input int k);
        if (k < 6) return 2'd1;
        if (k < 24) return 2'd2;
        return 2'd3;
    endfunction

    function automatic string req_of(input int k);
        if (k < 8) return "R5";
        if (k <= 23) return "R6";
        return "R7";
    endfunction

    // One frame: select, nfalls clock pulses, optional abort with a fall.
    task automatic run_frame(input logic [15:0] data, input int nfalls,
                             input int abort_k, input string start_req);
        @(negedge clk);
        sample_in = data;
        cs_n = 1'b0;
        push(1'b0, 1'b1, 1'b0, 2'd1, start_req);
        @(negedge clk);
        for (int k = 1; k <= nfalls; k++) begin
            sclk = 1'b1;
            if (k == 7) sample_in = ~data;
            push(last_exp.d, 1'b1, 1'b0, last_exp.ph, "R3 rising edge ignored");
            @(negedge clk);
            @(negedge clk);
            sclk = 1'b0;
            if (k == abort_k) begin
                cs_n = 1'b1;
                push(1'b0, 1'b0, 1'b1, 2'd0, "R8 abort with same-cycle fall");
                @(negedge clk);
                @(negedge clk);
                return;
            end
            push(exp_bit(data, k), 1'b1, 1'b0, exp_ph(k),
                 (k == 6) ? "R3 R4 conversion start" : req_of(k));
            @(negedge clk);
        end
        @(negedge clk);
        cs_n = 1'b1;
        push(1'b0, 1'b0, 1'b1, 2'd0, "R8 deselect");
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        push(1'b0, 1'b0, 1'b1, 2'd0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        run_frame(16'hA5C3, 27, 0, "R2 select");
        run_frame(16'h8001, 24, 0, "R2 select");
        run_frame(16'h3C96, 30, 12, "R2 select");
        run_frame(16'h7FFE, 24, 0, "R9 fresh frame after abort");
        run_frame(16'hFFFF, 10, 3, "R2 select");
        run_frame(16'h5A5A, 25, 0, "R9 fresh frame after early abort");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1-queue: %0d items unchecked, expected 0", exp_q.size());
        end
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule